// File: doc/BRIEF.md
# Multi-Device Parallel EPROM Read Controller

This block sits between a synchronous host and a bank of asynchronous 16-bit parallel EPROMs that share one address bus, one data bus and one read strobe. The host offers a request made of a word address and a device index. The controller accepts it only when the bus is free. It drives the address and pulls low the chip select of the indexed device, leaving every other device in standby. It lowers the shared read strobe later, returns the data word to the host, and then releases both lines.

Every wait is a whole number of clock cycles, derived at elaboration from the clock period and the speed grade. The speed grades run from 0 (fastest) to 4. Three timing limits of the part set the sequence:

- Address and chip-select access time: 90, 100, 120, 150 or 200 ns for grades 0 to 4.
- Read-strobe access time: 45, 50, 50, 60 or 90 ns for grades 0 to 4.
- Output float time: 30, 30, 40, 50 or 70 ns for grades 0 to 4.

The read strobe is held back for as long as it can be without lengthening the access. After release, the controller refuses new work until the data drivers of the device have had time to float. A following access, to the same device or to another, therefore cannot collide on the data bus.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every chip select is high (inactive), the read strobe is high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_ready` and `req_valid` are both 1. From that edge until the capture edge, only `mem_ce_n[req_dev]` is low: bit position equals the device index, and active is low. At no time is more than one chip select low.
- R3: The read strobe `mem_oe_n` falls D = floor((tACC - tOE) / Tclk) edges after the accepting edge and stays low until the capture edge. It is never low while every chip select is high.
- R4: The capture edge is the A-th edge after the accepting edge, with A = max(1, ceil(tACC / Tclk)). At that edge `rsp_data` takes the data bus. `rsp_valid` is then high for exactly one cycle.
- R5: The chip select and the read strobe both return high on the capture edge.
- R6: `req_ready` is 0 from the accepting edge until F = max(1, ceil(tFLOAT / Tclk)) edges after the capture edge. A request offered while `req_ready` is 0 has no effect on any output. The next chip-select fall comes at least tFLOAT after the previous release.
- R7: `mem_addr` equals the accepted address throughout the access and does not change while a chip select is low, whatever the host drives on `req_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read |
| req_addr | input | ADDR_W | Word address of the read |
| req_dev | input | DEV_W | Index of the device to read |
| req_ready | output | 1 | Controller can accept a read this cycle |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds a new word |
| rsp_data | output | DATA_W | Captured data word |
| mem_addr | output | ADDR_W | Shared EPROM address bus |
| mem_ce_n | output | NUM_DEV | Per-device chip select, active low |
| mem_oe_n | output | 1 | Shared read strobe, active low |
| mem_dq | input | DATA_W | Shared EPROM data bus |

## Verification
The assertions check several properties on every cycle: at most one chip select is low, the read strobe is never low without a chip select, the address is frozen while a device is selected, `req_ready` is low during an access, the response is a single pulse, and both strobes release together at capture. The exact edge counts cannot be checked this way: the read-strobe delay, the capture point and the float gap follow from the grade and clock arithmetic. Only the bench's sweep shows these. The bench runs each device over walking-one and extreme addresses against a timed EPROM model, which returns a wrong word whenever an access limit is cut short. That sweep also shows that requests offered while busy are ignored.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_ACCESS = 2'd1,
    RD_FLOAT  = 2'd2
  } rd_state_e;

  // address / chip-select access time in ns per grade
  function automatic int grade_t_acc(input int grade);
    case (grade)
      0:       return 90;
      1:       return 100;
      2:       return 120;
      3:       return 150;
      default: return 200;
    endcase
  endfunction

  // read-strobe access time in ns per grade
  function automatic int grade_t_oe(input int grade);
    case (grade)
      0:       return 45;
      1:       return 50;
      2:       return 50;
      3:       return 60;
      default: return 90;
    endcase
  endfunction

  // output float time in ns per grade
  function automatic int grade_t_float(input int grade);
    case (grade)
      0:       return 30;
      1:       return 30;
      2:       return 40;
      3:       return 50;
      default: return 70;
    endcase
  endfunction

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // cycles from select to capture
  function automatic int acc_cycles(input int grade, input int period_ns);
    return at_least_one(ceil_div(grade_t_acc(grade), period_ns));
  endfunction

  // latest strobe delay that does not lengthen the access
  function automatic int oe_delay_cycles(input int grade, input int period_ns);
    return (grade_t_acc(grade) - grade_t_oe(grade)) / period_ns;
  endfunction

  // cycles from release until the bus is free
  function automatic int float_cycles(input int grade, input int period_ns);
    return at_least_one(ceil_div(grade_t_float(grade), period_ns));
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
`timescale 1ns/1ps
module eprom_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             at_last
);

  assign count_nxt = clear ? '0 : count + 1'b1;
  assign at_last   = (count == last);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  // R4: a wait never runs past its programmed last count
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count > last) |-> $past(clear) == 1'b0 && 1'b0)
    else $error("wait counter passed its limit");

endmodule

// File: rtl/eprom_ce_decode.sv
`timescale 1ns/1ps
module eprom_ce_decode #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic               en,
  input  logic [DEV_W-1:0]   sel,
  output logic [NUM_DEV-1:0] ce_n
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign ce_n[i] = !(en && (sel == DEV_W'(i)));
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int NUM_DEV       = 4,
  localparam int DEV_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DEV_W-1:0]   req_dev,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_dq
);

  localparam int ACC_CYC = acc_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int OE_DLY  = oe_delay_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int FLT_CYC = float_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(max3(ACC_CYC, FLT_CYC, OE_DLY) + 1) + 1;

  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] FLT_LAST = CNT_W'(FLT_CYC - 1);
  localparam logic [CNT_W-1:0] OE_AT    = CNT_W'(OE_DLY);

  rd_state_e          state, state_nxt;
  logic [DEV_W-1:0]   dev_q, dev_nxt;
  logic [CNT_W-1:0]   cnt, cnt_nxt, cnt_last;
  logic               cnt_at_last, tmr_clear;
  logic [NUM_DEV-1:0] ce_n_nxt;

  // named events
  logic accept, capture_evt, float_done, ce_active;

  assign accept      = (state == RD_IDLE) && req_valid;
  assign capture_evt = (state == RD_ACCESS) && cnt_at_last;
  assign float_done  = (state == RD_FLOAT) && cnt_at_last;
  assign ce_active   = !(&mem_ce_n);
  assign req_ready   = (state == RD_IDLE);

  always_comb begin
    state_nxt = state;
    case (state)
      RD_IDLE:   if (accept)      state_nxt = RD_ACCESS;
      RD_ACCESS: if (capture_evt) state_nxt = RD_FLOAT;
      RD_FLOAT:  if (float_done)  state_nxt = RD_IDLE;
      default:                    state_nxt = RD_IDLE;
    endcase
  end

  assign dev_nxt   = accept ? req_dev : dev_q;
  assign tmr_clear = (state_nxt != state) || (state == RD_IDLE);
  assign cnt_last  = (state == RD_ACCESS) ? ACC_LAST : FLT_LAST;

  eprom_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tmr_clear),
    .last     (cnt_last),
    .count    (cnt),
    .count_nxt(cnt_nxt),
    .at_last  (cnt_at_last)
  );

  eprom_ce_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_dec (
    .en  (state_nxt == RD_ACCESS),
    .sel (dev_nxt),
    .ce_n(ce_n_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RD_IDLE;
      dev_q     <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= '1;
      mem_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state     <= state_nxt;
      dev_q     <= dev_nxt;
      mem_ce_n  <= ce_n_nxt;
      mem_oe_n  <= !((state_nxt == RD_ACCESS) && (cnt_nxt >= OE_AT));
      rsp_valid <= capture_evt;
      if (accept)      mem_addr <= req_addr;
      if (capture_evt) rsp_data <= mem_dq;
    end
  end

  // R2: never two devices selected together
  assert_one_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n))
    else $error("more than one chip select low");

  // R3: shared strobe only with a selected device
  assert_oe_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ce_active)
    else $error("read strobe low without chip select");

  // R4: response lasts one cycle
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");

  // R5: capture releases both lines at once
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (mem_oe_n && !ce_active && rsp_valid))
    else $error("lines not released at capture");

  // R6: no new work while a device is selected
  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_active |-> !req_ready)
    else $error("ready during access");

  // R7: address frozen during selection
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_active && $past(ce_active)) |-> $stable(mem_addr))
    else $error("address moved during access");

endmodule

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;

  localparam int T   = 20;
  localparam int ND  = 4;
  localparam real TACC = 90.0;
  localparam real TOE  = 45.0;
  localparam real TDF  = 30.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic [1:0]  req_dev;
  logic        req_ready, rsp_valid, mem_oe_n;
  logic [15:0] rsp_data, mem_addr, mem_dq;
  logic [ND-1:0] mem_ce_n;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // expected cycle counts, found by stepping through whole clock periods
  int n_acc, n_oe, n_flt;

  always #(T/2) clk = ~clk;

  eprom_rd_ctrl #(.CLK_PERIOD_NS(T), .SPEED_GRADE(0), .ADDR_W(16),
                  .DATA_W(16), .NUM_DEV(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_dev(req_dev), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  function automatic logic [15:0] word_of(input logic [15:0] a, input int d);
    return (a ^ 16'hA5C3) + 16'(d * 16'h0101);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // timed device model: wrong word unless every access limit is met
  realtime t_ce [ND];
  realtime t_oe, t_addr, t_rel;
  logic [ND-1:0] ce_prev = '1;

  initial begin
    for (int i = 0; i < ND; i++) t_ce[i] = 0.0;
    t_oe = 0.0; t_addr = 0.0; t_rel = -1000.0;
  end

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(mem_ce_n) begin
    for (int i = 0; i < ND; i++) begin
      if (ce_prev[i] && !mem_ce_n[i]) begin
        t_ce[i] = $realtime;
        // R6 float gap before a new selection
        chk(($realtime - t_rel) >= TDF, "R6 float gap", 32'($rtoi($realtime - t_rel)),
            32'($rtoi(TDF)));
      end
      if (!ce_prev[i] && mem_ce_n[i]) t_rel = $realtime;
    end
    ce_prev = mem_ce_n;
  end

  always begin
    int sel;
    #1;
    sel = -1;
    for (int i = 0; i < ND; i++) if (mem_ce_n[i] === 1'b0) sel = i;
    if (sel >= 0 && mem_oe_n === 1'b0 && ($realtime - t_ce[sel]) >= TACC &&
        ($realtime - t_oe) >= TOE && ($realtime - t_addr) >= TACC)
      mem_dq = word_of(mem_addr, sel);
    else
      mem_dq = 16'hDEAD;
  end

  task automatic do_read(input logic [15:0] a, input int d, input bit noisy);
    logic [3:0] ce_exp;
    ce_exp = ~(4'b1 << d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_dev = 2'(d);
    @(negedge clk);
    if (noisy) begin
      req_addr = ~a; req_dev = 2'(d + 1);
    end else begin
      req_valid = 1'b0;
    end
    for (int n = 1; n <= n_acc + n_flt + 1; n++) begin
      if (n > 1) @(negedge clk);
      if (n <= n_acc) begin
        chk(mem_ce_n == ce_exp, "R2 select", 32'(mem_ce_n), 32'(ce_exp));
        chk(mem_oe_n == !((n - 1) >= n_oe), "R3 strobe", 32'(mem_oe_n),
            32'(!((n - 1) >= n_oe)));
        chk(mem_addr == a, "R7 address", 32'(mem_addr), 32'(a));
        chk(req_ready == 1'b0, "R6 busy", 32'(req_ready), 32'd0);
      end
      if (n == n_acc + 1) begin
        chk(rsp_valid == 1'b1, "R4 valid", 32'(rsp_valid), 32'd1);
        chk(rsp_data == word_of(a, d), "R4 data", 32'(rsp_data), 32'(word_of(a, d)));
      end else begin
        chk(rsp_valid == 1'b0, "R4 no pulse", 32'(rsp_valid), 32'd0);
      end
      if (n > n_acc && n <= n_acc + n_flt) begin
        chk(mem_ce_n == 4'hF && mem_oe_n == 1'b1, "R5 released",
            32'({mem_ce_n, mem_oe_n}), 32'h1F);
        chk(req_ready == 1'b0, "R6 float wait", 32'(req_ready), 32'd0);
      end
      if (n == n_acc + n_flt + 1) begin
        chk(req_ready == 1'b1, "R6 ready back", 32'(req_ready), 32'd1);
        req_valid = 1'b0;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    n_acc = 1; while (real'(n_acc * T) < TACC) n_acc++;
    n_oe = 0;  while (real'((n_oe + 1) * T) <= TACC - TOE) n_oe++;
    n_flt = 1; while (real'(n_flt * T) < TDF) n_flt++;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_dev = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n == 4'hF && mem_oe_n && !rsp_valid && req_ready,
        "R1 in reset", 32'({mem_ce_n, mem_oe_n, rsp_valid, req_ready}), 32'h7D);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n == 4'hF && mem_oe_n && !rsp_valid && req_ready,
        "R1 after reset", 32'({mem_ce_n, mem_oe_n, rsp_valid, req_ready}), 32'h7D);
    for (int d = 0; d < ND; d++) begin
      for (int k = 0; k < 18; k++) begin
        logic [15:0] a;
        a = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(1 << (k - 2));
        do_read(a, d, k[0]);
      end
    end
    // back-to-back across devices, busy-time requests present
    for (int j = 0; j < 8; j++) do_read(16'(j * 16'h1357), (j * 3) % ND, 1'b1);
    finish_run();
  end

  initial begin
    #(200000 * T);
    vectors++;
    miscompares++;
    $display("FAIL watchdog R4 actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

endmodule